// File: doc/BRIEF.md
# DMA Control Register Decoder

This block holds the controller-wide control state of a four-channel DMA engine and decodes the upper half of its register window, offsets 8 through 15. A host writes or reads one byte per cycle. Each write updates one of four things: the command byte, the status byte, the channel mask, or one of the per-channel mode bytes. A write can also send a one-cycle pulse that clears the byte-pointer toggle, which lives in the address and count logic next to this block. Per-channel address and count registers and the transfer engine sit outside this block. The block drives out its stored state so that those neighbours can use it.

The status byte has two nibbles. The low nibble holds the terminal-count flags, one per channel. The high nibble holds the request flags, again one per channel. The transfer engine sets terminal-count flags through a pulse input. A read of status clears them. Request flags come from two sources: a software request write and a per-channel hardware request input. The hardware input wins when both hit the same channel in the same cycle. A master-clear write and the hardware reset both return the block to its idle state: every channel masked, status and command zero. The hardware reset also zeroes the mode bytes.

Top module: `dma_ctl_decode`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, the outputs are as follows: `cmd_o`=0, `status_o`=0, `mask_o`=all ones and `mode_o`=0. `ptr_clr_o` is 1 during reset, so the toggle starts cleared.
- R2: A write to offset 8 loads `cmd_o` only when the byte is 0x00 or has no bit set other than bit 2. Any other value leaves `cmd_o` unchanged.
- R3: A write to offset 9 selects channel c = data[1:0]. It sets status bit c+4 to data[2] and clears status bit c. The change shows on the next cycle.
- R4: When `req_valid_i[c]` is high, status bit c+4 takes `req_level_i[c]` on the next cycle. This overrides an offset-9 write to channel c in the same cycle, but that write still clears status bit c.
- R5: A write to offset 10 sets mask bit data[1:0] to data[2]. The other mask bits do not change.
- R6: A write to offset 11 stores the whole byte as the mode of channel data[1:0]. Channel c's mode appears at `mode_o[8c+7:8c]`. The other channels' modes do not change.
- R7: `ptr_clr_o` is high for exactly the one cycle after a write to offset 12 or 13. It is low after any other cycle.
- R8: A write to offset 13 sets the mask to all ones and clears status and command. This takes priority over same-cycle request and terminal-count inputs. Mode bytes are kept.
- R9: A write to offset 14 clears every mask bit. A write to offset 15 loads the mask from data[3:0].
- R10: A read of offset 8 returns the current status on `rdata_o` in the same cycle. On the next cycle the low nibble of status is zero, except for bits whose `tc_set_i` was high in the read cycle.
- R11: A read of offset 15 returns {4'b0, mask}. A read of any other offset returns 0, and `rdata_o` is 0 when `rd_en_i` is low.
- R12: A high `tc_set_i[c]` sets status bit c on the next cycle.
- R13: Writes to offsets 0 to 7 change no output of this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| offset_i | input | 4 | Register offset within the window |
| wr_en_i | input | 1 | Write strobe, one byte per cycle |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| tc_set_i | input | 4 | Terminal-count event per channel |
| req_valid_i | input | 4 | Hardware request update per channel |
| req_level_i | input | 4 | New request level per channel |
| rdata_o | output | 8 | Read data, valid in the cycle of `rd_en_i` |
| ptr_clr_o | output | 1 | Byte-pointer toggle clear pulse |
| cmd_o | output | 8 | Command byte |
| status_o | output | 8 | Status byte: request flags high nibble, terminal-count flags low nibble |
| mask_o | output | 4 | Channel mask, 1 = masked |
| mode_o | output | 32 | Per-channel mode bytes, channel 0 in the low byte |

## Verification
The assertions assume that `rd_en_i` and `wr_en_i` are never high in the same cycle. They also assume the inputs settle well clear of the clock edge, because read data comes straight from the stored state with no register in between. The stimulus issues each access as its own cycle, with one strobe at a time. It changes inputs a fixed delay after the rising edge. Request and terminal-count pulses are raised only within a single access cycle, so the properties that compare against the previous cycle always see exactly one source of change.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

    // Offsets whose positions the host software depends on
    typedef enum logic [3:0] {
        OFF_CMD_STAT = 4'd8,
        OFF_SW_REQ   = 4'd9,
        OFF_ONE_MASK = 4'd10,
        OFF_MODE     = 4'd11,
        OFF_PTR_CLR  = 4'd12,
        OFF_MCLR     = 4'd13,
        OFF_MASK_ZERO= 4'd14,
        OFF_MASK_ALL = 4'd15
    } ctl_off_e;

    // One-hot write decode of the control window
    typedef struct packed {
        logic cmd;
        logic sw_req;
        logic one_mask;
        logic mode;
        logic ptr_clr;
        logic mclr;
        logic mask_zero;
        logic mask_all;
    } wr_strobe_t;

    // Layout of a stored mode byte, as read by the transfer engine
    typedef struct packed {
        logic [1:0] op_mode;
        logic       decrement;
        logic       auto_init;
        logic [1:0] xfer_type;
        logic [1:0] chan_sel;
    } mode_byte_t;

endpackage

// File: rtl/dma_ctl_wdec.sv
module dma_ctl_wdec
    import dma_ctl_pkg::*;
(
    input  logic       wr_en_i,
    input  logic [3:0] offset_i,
    output wr_strobe_t strobe_o
);

    always_comb begin
        strobe_o = '0;
        if (wr_en_i) begin
            case (offset_i)
                OFF_CMD_STAT:  strobe_o.cmd       = 1'b1;
                OFF_SW_REQ:    strobe_o.sw_req    = 1'b1;
                OFF_ONE_MASK:  strobe_o.one_mask  = 1'b1;
                OFF_MODE:      strobe_o.mode      = 1'b1;
                OFF_PTR_CLR:   strobe_o.ptr_clr   = 1'b1;
                OFF_MCLR:      strobe_o.mclr      = 1'b1;
                OFF_MASK_ZERO: strobe_o.mask_zero = 1'b1;
                OFF_MASK_ALL:  strobe_o.mask_all  = 1'b1;
                default:       strobe_o           = '0;
            endcase
        end
    end

endmodule

// File: rtl/dma_ctl_status.sv
module dma_ctl_status #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic [2*NUM_CH-1:0] stat_q_i,
    input  logic                sw_req_i,
    input  logic [CH_W-1:0]     sel_i,
    input  logic                set_bit_i,
    input  logic                rd_clr_i,
    input  logic [NUM_CH-1:0]   tc_set_i,
    input  logic [NUM_CH-1:0]   req_valid_i,
    input  logic [NUM_CH-1:0]   req_level_i,
    input  logic                mclr_i,
    output logic [2*NUM_CH-1:0] stat_d_o
);

    logic [2*NUM_CH-1:0] work;

    always_comb begin
        work = stat_q_i;
        // software request: request flag follows data, terminal count drops
        if (sw_req_i) begin
            work[NUM_CH + int'(sel_i)] = set_bit_i;
            work[int'(sel_i)]          = 1'b0;
        end
        // status read clears the terminal-count nibble
        if (rd_clr_i) begin
            work[NUM_CH-1:0] = '0;
        end
        // a new terminal-count event is never lost to a read
        work[NUM_CH-1:0] = work[NUM_CH-1:0] | tc_set_i;
        // hardware request overrides the software write per channel
        for (int c = 0; c < NUM_CH; c++) begin
            if (req_valid_i[c]) begin
                work[NUM_CH + c] = req_level_i[c];
            end
        end
        if (mclr_i) begin
            work = '0;
        end
        stat_d_o = work;
    end

endmodule

// File: rtl/dma_ctl_rmux.sv
module dma_ctl_rmux
    import dma_ctl_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DW     = 8
) (
    input  logic                rd_en_i,
    input  logic [3:0]          offset_i,
    input  logic [2*NUM_CH-1:0] stat_i,
    input  logic [NUM_CH-1:0]   mask_i,
    output logic [DW-1:0]       rdata_o
);

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            case (offset_i)
                OFF_CMD_STAT: rdata_o[2*NUM_CH-1:0] = stat_i;
                OFF_MASK_ALL: rdata_o[NUM_CH-1:0]   = mask_i;
                default:      rdata_o               = '0;
            endcase
        end
    end

endmodule

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
    import dma_ctl_pkg::*;
#(
    parameter int          NUM_CH     = 4,
    parameter int          DW         = 8,
    parameter logic [7:0]  CMD_ACCEPT = 8'h04
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           offset_i,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [DW-1:0]        wdata_i,
    input  logic [NUM_CH-1:0]    tc_set_i,
    input  logic [NUM_CH-1:0]    req_valid_i,
    input  logic [NUM_CH-1:0]    req_level_i,
    output logic [DW-1:0]        rdata_o,
    output logic                 ptr_clr_o,
    output logic [DW-1:0]        cmd_o,
    output logic [2*NUM_CH-1:0]  status_o,
    output logic [NUM_CH-1:0]    mask_o,
    output logic [NUM_CH*DW-1:0] mode_o
);

    localparam int CH_W   = $clog2(NUM_CH);
    localparam int SET_IX = CH_W;

    typedef struct packed {
        logic [DW-1:0]             cmd;
        logic [2*NUM_CH-1:0]       stat;
        logic [NUM_CH-1:0]         mask;
        logic [NUM_CH-1:0][DW-1:0] mode;
        logic                      ptr_clr;
    } ctl_state_t;

    ctl_state_t          s_d, s_q;
    wr_strobe_t          strobe;
    logic [2*NUM_CH-1:0] stat_d;
    logic [CH_W-1:0]     sel;
    logic                cmd_ok;
    logic                rd_clr;

    assign sel    = wdata_i[CH_W-1:0];
    assign cmd_ok = (wdata_i == '0) || ((wdata_i & ~CMD_ACCEPT) == '0);
    assign rd_clr = rd_en_i && (offset_i == OFF_CMD_STAT);

    dma_ctl_wdec i_wdec (
        .wr_en_i  (wr_en_i),
        .offset_i (offset_i),
        .strobe_o (strobe)
    );

    dma_ctl_status #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_status (
        .stat_q_i    (s_q.stat),
        .sw_req_i    (strobe.sw_req),
        .sel_i       (sel),
        .set_bit_i   (wdata_i[SET_IX]),
        .rd_clr_i    (rd_clr),
        .tc_set_i    (tc_set_i),
        .req_valid_i (req_valid_i),
        .req_level_i (req_level_i),
        .mclr_i      (strobe.mclr),
        .stat_d_o    (stat_d)
    );

    dma_ctl_rmux #(.NUM_CH(NUM_CH), .DW(DW)) i_rmux (
        .rd_en_i  (rd_en_i),
        .offset_i (offset_i),
        .stat_i   (s_q.stat),
        .mask_i   (s_q.mask),
        .rdata_o  (rdata_o)
    );

    always_comb begin
        s_d         = s_q;
        s_d.stat    = stat_d;
        s_d.ptr_clr = strobe.ptr_clr | strobe.mclr;

        if (strobe.cmd && cmd_ok) begin
            s_d.cmd = wdata_i;
        end

        if (strobe.one_mask) begin
            s_d.mask[sel] = wdata_i[SET_IX];
        end
        if (strobe.mask_zero) begin
            s_d.mask = '0;
        end
        if (strobe.mask_all) begin
            s_d.mask = wdata_i[NUM_CH-1:0];
        end

        for (int c = 0; c < NUM_CH; c++) begin
            if (strobe.mode && (int'(sel) == c)) begin
                s_d.mode[c] = wdata_i;
            end
        end

        if (strobe.mclr) begin
            s_d.mask = '1;
            s_d.cmd  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cmd     <= '0;
            s_q.stat    <= '0;
            s_q.mask    <= '1;
            s_q.mode    <= '0;
            s_q.ptr_clr <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ptr_clr_o = s_q.ptr_clr;
    assign cmd_o     = s_q.cmd;
    assign status_o  = s_q.stat;
    assign mask_o    = s_q.mask;
    assign mode_o    = s_q.mode;

endmodule

// File: rtl/dma_ctl_decode_chk.sv
module dma_ctl_decode_chk #(
    parameter int NUM_CH = 4,
    parameter int DW     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [3:0]           offset_i,
    input logic                 wr_en_i,
    input logic                 rd_en_i,
    input logic [DW-1:0]        wdata_i,
    input logic [NUM_CH-1:0]    tc_set_i,
    input logic [NUM_CH-1:0]    req_valid_i,
    input logic [NUM_CH-1:0]    req_level_i,
    input logic [DW-1:0]        rdata_o,
    input logic                 ptr_clr_o,
    input logic [DW-1:0]        cmd_o,
    input logic [2*NUM_CH-1:0]  status_o,
    input logic [NUM_CH-1:0]    mask_o,
    input logic [NUM_CH*DW-1:0] mode_o
);

    logic mclr_wr;
    assign mclr_wr = wr_en_i && (offset_i == 4'd13);

    // R2: a rejected command byte leaves the command register alone
    assert_cmd_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && offset_i == 4'd8 && wdata_i != 8'h00 && (wdata_i & 8'hFB) != 8'h00)
        |=> $stable(cmd_o));

    // R7: no clear pulse without a toggle-clearing write
    assert_ptr_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && (offset_i == 4'd12 || offset_i == 4'd13)) |=> !ptr_clr_o);

    // R8: master clear
    assert_master_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_wr |=> (mask_o == '1 && status_o == '0 && cmd_o == '0 && ptr_clr_o));

    // R9: clear-all-mask write
    assert_mask_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && offset_i == 4'd14) |=> (mask_o == '0));

    // R10: status read without new events empties the terminal-count nibble
    assert_stat_rd_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && offset_i == 4'd8 && tc_set_i == '0) |=> (status_o[NUM_CH-1:0] == '0));

    // R11: idle read bus
    assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |-> (rdata_o == '0));

    // R12: terminal-count events always land unless master clear
    assert_tc_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_set_i != '0 && !mclr_wr) |=> ((status_o[NUM_CH-1:0] & $past(tc_set_i)) == $past(tc_set_i)));

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_req
            // R4: hardware request level wins for its channel
            assert_hw_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid_i[c] && !mclr_wr) |=> (status_o[NUM_CH + c] == $past(req_level_i[c])));
        end
    endgenerate

endmodule

bind dma_ctl_decode dma_ctl_decode_chk #(.NUM_CH(NUM_CH), .DW(DW)) i_chk (.*);

// File: tb/test_dma_ctl_decode.sv
module test_dma_ctl_decode;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  offset_i = '0;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [7:0]  wdata_i = '0;
    logic [3:0]  tc_set_i = '0;
    logic [3:0]  req_valid_i = '0;
    logic [3:0]  req_level_i = '0;
    logic [7:0]  rdata_o;
    logic        ptr_clr_o;
    logic [7:0]  cmd_o;
    logic [7:0]  status_o;
    logic [3:0]  mask_o;
    logic [31:0] mode_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] m_cmd, m_stat;
    logic [3:0] m_mask;
    logic [7:0] m_mode [4];
    logic       m_ptr;

    dma_ctl_decode i_dma_ctl_decode (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " cmd"},    {24'h0, cmd_o},     {24'h0, m_cmd});
        chk({tag, " status"}, {24'h0, status_o},  {24'h0, m_stat});
        chk({tag, " mask"},   {28'h0, mask_o},    {28'h0, m_mask});
        chk({tag, " mode"},   mode_o, {m_mode[3], m_mode[2], m_mode[1], m_mode[0]});
        chk({tag, " ptr_clr"}, {31'h0, ptr_clr_o}, {31'h0, m_ptr});
    endtask

    task automatic model_reset();
        m_cmd = '0; m_stat = '0; m_mask = '1; m_ptr = 1'b1;
        for (int c = 0; c < 4; c++) m_mode[c] = '0;
    endtask

    // One access cycle; inputs move one time unit after the rising edge
    task automatic op(input string tag, input logic wr, input logic rd, input logic [3:0] off,
                      input logic [7:0] d, input logic [3:0] tc, input logic [3:0] rv,
                      input logic [3:0] rl);
        logic [7:0] exp_rd;
        int ch;
        wr_en_i = wr; rd_en_i = rd; offset_i = off; wdata_i = d;
        tc_set_i = tc; req_valid_i = rv; req_level_i = rl;
        #1;
        exp_rd = 8'h00;
        if (rd && off == 4'd8)  exp_rd = m_stat;
        if (rd && off == 4'd15) exp_rd = {4'h0, m_mask};
        chk({tag, " rdata"}, {24'h0, rdata_o}, {24'h0, exp_rd});
        ch = int'(d[1:0]);
        m_ptr = wr && (off == 4'd12 || off == 4'd13);
        if (wr) begin
            case (off)
                4'd8:  if (d == 8'h00 || (d & 8'hFB) == 8'h00) m_cmd = d;
                4'd9:  begin m_stat[ch+4] = d[2]; m_stat[ch] = 1'b0; end
                4'd10: m_mask[ch] = d[2];
                4'd11: m_mode[ch] = d;
                4'd14: m_mask = 4'h0;
                4'd15: m_mask = d[3:0];
                default: ;
            endcase
        end
        if (rd && off == 4'd8) m_stat[3:0] = 4'h0;
        m_stat[3:0] = m_stat[3:0] | tc;
        for (int c = 0; c < 4; c++) if (rv[c]) m_stat[c+4] = rl[c];
        if (wr && off == 4'd13) begin
            m_mask = 4'hF; m_stat = 8'h00; m_cmd = 8'h00;
        end
        @(posedge clk);
        #1;
        wr_en_i = 1'b0; rd_en_i = 1'b0; wdata_i = '0; offset_i = '0;
        tc_set_i = '0; req_valid_i = '0; req_level_i = '0;
        check_all(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_reset();
        #(CLK_PERIOD * 3 + 1);
        check_all("R1 in reset");
        @(posedge clk); #1;
        rst_n = 1'b1;
        check_all("R1 after release");

        // R2: every command value
        for (int v = 0; v < 256; v++) begin
            op("R2 cmd", 1, 0, 4'd8, 8'(v), 0, 0, 0);
        end

        // R12 then R3: raise terminal counts, then software requests per channel
        for (int ch = 0; ch < 4; ch++) begin
            for (int b = 0; b < 2; b++) begin
                op("R12 tc", 0, 0, 4'd0, 8'h00, 4'hF, 0, 0);
                op("R3 swreq", 1, 0, 4'd9, 8'(ch | (b << 2) | 8'hF8), 0, 0, 0);
            end
        end

        // R4: hardware level against an opposite software write, same channel and not
        for (int ch = 0; ch < 4; ch++) begin
            op("R4 pre", 0, 0, 4'd0, 0, 4'hF, 0, 0);
            op("R4 win", 1, 0, 4'd9, 8'(ch | 4), 0, 4'(1 << ch), 4'h0);
            op("R4 win", 1, 0, 4'd9, 8'(ch), 0, 4'(1 << ch), 4'hF);
            op("R4 other", 1, 0, 4'd9, 8'(ch | 4), 0, 4'(1 << ((ch + 1) % 4)), 4'h0);
        end

        // R5: single-bit mask writes, all encodings, twice over
        for (int r = 0; r < 2; r++) begin
            for (int v = 0; v < 8; v++) begin
                op("R5 onemask", 1, 0, 4'd10, 8'(v ^ (r * 4)), 0, 0, 0);
            end
        end

        // R6: mode bytes per channel
        for (int r = 0; r < 3; r++) begin
            for (int ch = 0; ch < 4; ch++) begin
                op("R6 mode", 1, 0, 4'd11, 8'(((r * 67 + ch * 29) & 8'hFC) | ch), 0, 0, 0);
            end
        end

        // R7: toggle clear pulse, then quiet
        op("R7 pclr", 1, 0, 4'd12, 8'hAA, 0, 0, 0);
        op("R7 quiet", 0, 0, 4'd0, 8'h00, 0, 0, 0);

        // R9: mask clear and load sweep
        op("R9 zero", 1, 0, 4'd14, 8'hFF, 0, 0, 0);
        for (int v = 0; v < 16; v++) begin
            op("R9 load", 1, 0, 4'd15, 8'(v | 8'hA0), 0, 0, 0);
        end

        // R10: status read clears terminal counts, same-cycle event survives
        op("R10 setup", 1, 0, 4'd9, 8'h06, 4'hF, 0, 0);
        op("R10 read", 0, 1, 4'd8, 8'h00, 0, 0, 0);
        op("R10 refill", 0, 0, 4'd0, 8'h00, 4'h5, 0, 0);
        op("R10 read tc", 0, 1, 4'd8, 8'h00, 4'h2, 0, 0);
        op("R10 read again", 0, 1, 4'd8, 8'h00, 0, 0, 0);

        // R11: read every offset
        op("R11 setmask", 1, 0, 4'd15, 8'h09, 0, 0, 0);
        op("R11 settc", 0, 0, 4'd0, 8'h00, 4'h3, 4'hC, 4'hC);
        for (int o = 0; o < 16; o++) begin
            if (o != 8) op("R11 read", 0, 1, 4'(o), 8'h00, 0, 0, 0);
        end

        // R13: writes below the window change nothing
        for (int o = 0; o < 8; o++) begin
            op("R13 lowwr", 1, 0, 4'(o), 8'(8'hFF - o * 13), 0, 0, 0);
        end

        // R8: master clear wins over same-cycle events, modes kept
        op("R8 mclr", 1, 0, 4'd13, 8'h00, 4'hF, 4'hF, 4'hF);
        op("R8 after", 1, 0, 4'd8, 8'h04, 0, 0, 0);
        op("R8 again", 1, 0, 4'd13, 8'h5A, 0, 0, 0);

        // R1: hardware reset clears modes too
        rst_n = 1'b0;
        model_reset();
        #(CLK_PERIOD);
        check_all("R1 re-reset");
        @(posedge clk); #1;
        rst_n = 1'b1;

        finish_run();
    end

endmodule